// File: doc/BRIEF.md
# Sample Packetizer with Alternating Buffers

This block takes sample records from a capture controller and sends them as fixed-size packets on an AXI4-Stream master. Every accepted sample becomes one record. A record is a tag word followed by the sample number and then one word per channel. Once a packet's worth of records has gone out, the packet is complete. The block then raises a level interrupt and reports which of the two destination buffers has just been filled.

Consecutive packets alternate between buffer 0 and buffer 1. A downstream DMA writer can fill one buffer while the host drains the other. The tag word carries a packet sequence number, so a receiver can put reordered packets back in order.

Top module: `sample_packetizer`

## Requirements
- R1: After reset, `m_tvalid_o`, `m_tlast_o`, `irq_o`, `ovf_o` and `buf_sel_o` are all 0.
- R2: A sample presented on `smp_valid_i` while no record is pending is accepted. Its record is then sent as 2+NUM_CH beats, in this order: tag word, sample number, channel 0, and so on up to channel NUM_CH-1. Channel k is taken from bits [32k+31:32k] of `ch_data_i`.
- R3: The tag word holds TYPE_CODE (default 8'hA5) in bits [31:24] and zero in bits [23:16]. Bits [15:0] hold the packet sequence number, which starts at 0 after reset and increases by one for each completed packet.
- R4: `m_tlast_o` is high only on the final beat of the PKT_RECS-th record of a packet.
- R5: While `m_tvalid_o` is high and `m_tready_i` is low, `m_tvalid_o`, `m_tdata_o` and `m_tlast_o` hold their values.
- R6: The cycle after the final beat of a packet is accepted, `irq_o` is high. It stays high until a cycle in which `irq_ack_i` is high.
- R7: `buf_sel_o` names the buffer of the most recently completed packet. Packets go to buffers 0, 1, 0, 1 and so on, starting from 0, and `buf_sel_o` changes only when a packet completes.
- R8: A sample that arrives while a record is still pending (`m_tvalid_o` high) is dropped and sets `ovf_o`. `ovf_o` then stays high until reset.
- R9: A dropped sample produces no beats. The pending record goes out unchanged, and the stream goes idle afterwards.
- R10: If a packet completes in the same cycle as `irq_ack_i`, the completion wins and `irq_o` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_num_i | input | 32 | Sample number (timestamp) |
| ch_data_i | input | NUM_CH*32 | Channel values, channel 0 in the low word |
| m_tdata_o | output | 32 | Stream data |
| m_tvalid_o | output | 1 | Stream valid |
| m_tready_i | input | 1 | Stream ready |
| m_tlast_o | output | 1 | Last beat of a packet |
| buf_sel_o | output | 1 | Buffer of the last completed packet |
| irq_o | output | 1 | Packet-ready interrupt (level) |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is a packet completing in exactly the cycle the host acknowledges the previous interrupt. The bench reaches it by holding the acknowledge high for the whole of a packet, so the final handshake lands on an acknowledge cycle. Overflow needs a stalled stream. The bench holds ready low with a record pending and strobes a second sample, then checks that only the first record comes out.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sp_beat_sel.sv
module sp_beat_sel #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned BEAT_W = 3
) (
  input  sp_pkg::word_t                   tag_i,
  input  sp_pkg::word_t                   num_i,
  input  logic [NUM_CH*sp_pkg::WORD_W-1:0] ch_i,
  input  logic [BEAT_W-1:0]               beat_i,
  output sp_pkg::word_t                   word_o
);
  localparam int unsigned BEATS = 2 + NUM_CH;

  sp_pkg::word_t words [BEATS];

  assign words[0] = tag_i;
  assign words[1] = num_i;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign words[k+2] = ch_i[k*sp_pkg::WORD_W +: sp_pkg::WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int unsigned i = 0; i < BEATS; i++) begin
      if (beat_i == BEAT_W'(i)) word_o = words[i];
    end
  end
endmodule

// File: rtl/sp_pkt_track.sv
module sp_pkt_track #(
  parameter int unsigned PKT_RECS = 32,
  parameter int unsigned SEQ_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rec_done_i,
  output logic             last_rec_o,
  output logic             pkt_done_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             wr_buf_o
);
  localparam int unsigned REC_W = (PKT_RECS > 1) ? $clog2(PKT_RECS) : 1;

  logic [REC_W-1:0] rec_q;

  assign last_rec_o = (rec_q == REC_W'(PKT_RECS - 1));
  assign pkt_done_o = rec_done_i && last_rec_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q    <= '0;
      seq_o    <= '0;
      wr_buf_o <= 1'b0;
    end else if (rec_done_i) begin
      if (last_rec_o) begin
        rec_q    <= '0;
        seq_o    <= seq_o + 1'b1;
        wr_buf_o <= ~wr_buf_o;
      end else begin
        rec_q <= rec_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_irq_ctrl.sv
module sp_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pkt_done_i,
  input  logic wr_buf_i,
  input  logic ack_i,
  output logic irq_o,
  output logic buf_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      buf_sel_o <= 1'b0;
    end else begin
      // completion beats a coincident ack
      if (pkt_done_i) begin
        irq_o     <= 1'b1;
        buf_sel_o <= wr_buf_i;
      end else if (ack_i) begin
        irq_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sample_packetizer.sv
module sample_packetizer #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned PKT_RECS  = 32,
  parameter int unsigned SEQ_W     = 16,
  parameter logic [7:0]  TYPE_CODE = 8'hA5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            smp_valid_i,
  input  logic [31:0]                     smp_num_i,
  input  logic [NUM_CH*sp_pkg::WORD_W-1:0] ch_data_i,
  output logic [31:0]                     m_tdata_o,
  output logic                            m_tvalid_o,
  input  logic                            m_tready_i,
  output logic                            m_tlast_o,
  output logic                            buf_sel_o,
  output logic                            irq_o,
  input  logic                            irq_ack_i,
  output logic                            ovf_o
);
  localparam int unsigned BEATS  = 2 + NUM_CH;
  localparam int unsigned BEAT_W = $clog2(BEATS);

  logic                             busy_q;
  logic [BEAT_W-1:0]                beat_q;
  sp_pkg::word_t                    num_q;
  logic [NUM_CH*sp_pkg::WORD_W-1:0] ch_q;

  logic             accept, hs, beat_last, rec_done;
  logic             last_rec, pkt_done, wr_buf;
  logic [SEQ_W-1:0] seq;
  sp_pkg::word_t    tag_word;

  assign accept    = smp_valid_i && !busy_q;
  assign hs        = busy_q && m_tready_i;
  assign beat_last = (beat_q == BEAT_W'(BEATS - 1));
  assign rec_done  = hs && beat_last;
  assign tag_word  = {TYPE_CODE, 24'(seq)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      num_q  <= '0;
      ch_q   <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        beat_q <= '0;
        num_q  <= smp_num_i;
        ch_q   <= ch_data_i;
      end else if (rec_done) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else if (hs) begin
        beat_q <= beat_q + 1'b1;
      end
      // sample during a pending record is dropped
      if (smp_valid_i && busy_q) ovf_o <= 1'b1;
    end
  end

  sp_beat_sel #(.NUM_CH(NUM_CH), .BEAT_W(BEAT_W)) u_sel (
    .tag_i  (tag_word),
    .num_i  (num_q),
    .ch_i   (ch_q),
    .beat_i (beat_q),
    .word_o (m_tdata_o)
  );

  sp_pkt_track #(.PKT_RECS(PKT_RECS), .SEQ_W(SEQ_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rec_done_i (rec_done),
    .last_rec_o (last_rec),
    .pkt_done_o (pkt_done),
    .seq_o      (seq),
    .wr_buf_o   (wr_buf)
  );

  sp_irq_ctrl u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_done_i (pkt_done),
    .wr_buf_i   (wr_buf),
    .ack_i      (irq_ack_i),
    .irq_o      (irq_o),
    .buf_sel_o  (buf_sel_o)
  );

  assign m_tvalid_o = busy_q;
  assign m_tlast_o  = busy_q && beat_last && last_rec;
endmodule

// File: rtl/sample_packetizer_chk.sv
module sample_packetizer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        smp_valid_i,
  input logic [31:0] m_tdata_o,
  input logic        m_tvalid_o,
  input logic        m_tready_i,
  input logic        m_tlast_o,
  input logic        buf_sel_o,
  input logic        irq_o,
  input logic        irq_ack_i,
  input logic        ovf_o
);
  a_r5_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o));

  a_r4_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tlast_o |-> m_tvalid_o);

  a_r6_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_ack_i |=> irq_o);

  // R6 / R10: completion always leaves irq high
  a_r10_done_sets_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tready_i && m_tlast_o |=> irq_o);

  a_r7_buf_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_tvalid_o && m_tready_i && m_tlast_o) |=> $stable(buf_sel_o));

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  a_r8_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && m_tvalid_o |=> ovf_o);
endmodule

bind sample_packetizer sample_packetizer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .m_tdata_o   (m_tdata_o),
  .m_tvalid_o  (m_tvalid_o),
  .m_tready_i  (m_tready_i),
  .m_tlast_o   (m_tlast_o),
  .buf_sel_o   (buf_sel_o),
  .irq_o       (irq_o),
  .irq_ack_i   (irq_ack_i),
  .ovf_o       (ovf_o)
);

// File: tb/sample_packetizer_test.sv
`timescale 1ns/1ps
module sample_packetizer_test;
  localparam int unsigned NCH  = 4;
  localparam int unsigned RECS = 4;
  localparam int unsigned NV   = 8;

  // rows: sample number, ch0..ch3
  localparam logic [31:0] VEC [NV][5] = '{
    '{32'h0000_0100, 32'h1111_0000, 32'h2222_0000, 32'h3333_0000, 32'h4444_0000},
    '{32'h0000_0101, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 32'h7FFF_FFFE},
    '{32'h0000_0102, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h0123_4567, 32'h89AB_CDEF},
    '{32'h0000_0103, 32'h0000_0001, 32'h0000_0002, 32'h0000_0004, 32'h0000_0008},
    '{32'h0000_0200, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0F0F_0F0F, 32'hF0F0_F0F0},
    '{32'h0000_0201, 32'h1234_5678, 32'h9ABC_DEF0, 32'h1357_9BDF, 32'h2468_ACE0},
    '{32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_FF00, 32'h00FF_0000, 32'hFF00_0000},
    '{32'h0000_0000, 32'h7777_7777, 32'h8888_8888, 32'h9999_9999, 32'hAAAA_AAAA}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic [31:0]       smp_num = '0;
  logic [NCH*32-1:0] ch_data = '0;
  logic [31:0]       tdata;
  logic              tvalid, tready, tlast, buf_sel, irq, irq_ack, ovf;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sample_packetizer #(.NUM_CH(NCH), .PKT_RECS(RECS)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_valid_i (smp_valid),
    .smp_num_i   (smp_num),
    .ch_data_i   (ch_data),
    .m_tdata_o   (tdata),
    .m_tvalid_o  (tvalid),
    .m_tready_i  (tready),
    .m_tlast_o   (tlast),
    .buf_sel_o   (buf_sel),
    .irq_o       (irq),
    .irq_ack_i   (irq_ack),
    .ovf_o       (ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tag(input int seq);
    return {8'hA5, 8'h00, 16'(seq)};
  endfunction

  task automatic send(input logic [31:0] num, input logic [31:0] c0, c1, c2, c3);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_num   = num;
    ch_data   = {c3, c2, c1, c0};
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // expects beat 0 visible now and tready high
  task automatic collect(input logic [31:0] num, c0, c1, c2, c3,
                         input int seq, input bit last);
    logic [31:0] exp [6];
    exp = '{tag(seq), num, c0, c1, c2, c3};
    for (int b = 0; b < 6; b++) begin
      chk("R2 tvalid", {31'd0, tvalid}, 32'd1);
      chk(b == 0 ? "R3 tag word" : "R2 beat data", tdata, exp[b]);
      chk("R4 tlast", {31'd0, tlast}, {31'd0, last && (b == 5)});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tready  = 1'b1;
    irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tvalid", {31'd0, tvalid}, 32'd0);
    chk("R1 tlast", {31'd0, tlast}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 ovf", {31'd0, ovf}, 32'd0);
    chk("R1 buf_sel", {31'd0, buf_sel}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: two packets, R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      collect(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
              i / RECS, (i % RECS) == RECS - 1);
      chk("R9 idle after record", {31'd0, tvalid}, 32'd0);
      if ((i % RECS) == RECS - 1) begin
        chk("R6 irq set", {31'd0, irq}, 32'd1);
        chk("R7 buf_sel", {31'd0, buf_sel}, 32'((i / RECS) % 2));
        @(negedge clk);
        chk("R6 irq held", {31'd0, irq}, 32'd1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R6 irq cleared", {31'd0, irq}, 32'd0);
      end else begin
        chk("R6 no irq mid-packet", {31'd0, irq}, 32'd0);
      end
    end
    chk("R8 no ovf yet", {31'd0, ovf}, 32'd0);

    // stall and overflow: R5 R8 R9
    tready = 1'b0;
    send(32'h0000_0500, 32'hA0, 32'hA1, 32'hA2, 32'hA3);
    chk("R5 stalled valid", {31'd0, tvalid}, 32'd1);
    chk("R5 stalled tag", tdata, tag(2));
    send(32'h0000_0666, 32'hB0, 32'hB1, 32'hB2, 32'hB3);
    chk("R8 ovf set", {31'd0, ovf}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 tag held", tdata, tag(2));
    chk("R5 valid held", {31'd0, tvalid}, 32'd1);
    tready = 1'b1;
    collect(32'h0000_0500, 32'hA0, 32'hA1, 32'hA2, 32'hA3, 2, 1'b0);
    chk("R9 dropped sample not sent", {31'd0, tvalid}, 32'd0);

    // completion coincident with ack: R10
    irq_ack = 1'b1;
    for (int j = 1; j < RECS; j++) begin
      send(32'h700 + 32'(j), 32'(j), 32'(j * 2), 32'(j * 3), 32'(j * 4));
      collect(32'h700 + 32'(j), 32'(j), 32'(j * 2), 32'(j * 3), 32'(j * 4),
              2, j == RECS - 1);
    end
    chk("R10 irq wins over ack", {31'd0, irq}, 32'd1);
    chk("R7 third packet buffer", {31'd0, buf_sel}, 32'd0);
    irq_ack = 1'b0;
    @(negedge clk);
    chk("R6 irq held after ack drop", {31'd0, irq}, 32'd1);
    chk("R8 ovf sticky", {31'd0, ovf}, 32'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule